// File: doc/BRIEF.md
# Cascadable Interrupt Controller Front End

This block is the programming and acknowledge front end of a cascadable eight-line interrupt controller. The CPU configures it with single-cycle I/O writes at two offsets, selected by `wr_a0`. A write at offset 0 with data bit 4 set starts initialization. Exactly three writes at offset 1 must follow: the vector base, then the cascade word, then a final mode word. There is no shorter path. Once the last of these writes lands, later offset-1 writes load the interrupt mask.

When initialized, the block latches request lines into a pending register. It raises `int_out` while any unmasked request is pending. It answers a two-strobe acknowledge handshake:
- On the first strobe it resolves the winner by fixed priority, where the lowest index wins.
- On the second strobe it returns the vector byte, unless the cascade word hands the bus to a different controller.

The same module serves as master or slave, chosen by the `is_slave` pin. Writes and acknowledge strobes are plain one-cycle pulses that the block accepts every cycle. It applies no back-pressure and needs no valid/ready pairing.

Top module: `pic_front`

## Requirements
- R1: A write at offset 0 (`wr_a0`=0) with `wr_data[4]`=1 restarts initialization. From the next cycle `init_done` is 0, and the mask, pending and `in_service` bits are all cleared.
- R2: After the restart, three writes at offset 1 must follow in this order: the vector base, then the cascade word, then the mode word. `init_done` rises in the cycle after the third write and not before, whatever bits the restart write carried.
- R3: An offset-0 write with `wr_data[4]`=0 changes no state.
- R4: While `init_done` is 0, request lines are not latched, `int_out` stays 0, and acknowledge strobes produce no vector.
- R5: After initialization, an offset-1 write loads the mask. A mask bit of 1 excludes that line from `int_out` and from winner selection.
- R6: A request line high for one cycle sets its pending bit. If the line is unmasked, `int_out` is 1 in the following cycle.
- R7: On the first acknowledge strobe, the lowest-index unmasked pending line wins. Its `in_service` bit is set and its pending bit is cleared.
- R8: On the second strobe, when the block drives the bus, `vec_valid` is high for exactly one cycle, starting the cycle after the strobe. `vec_data` then equals the vector base bits 7..3 in bits 7..3, and the winning index in bits 2..0.
- R9: If no unmasked line is pending at the first strobe, the index is 7. No `in_service` bit or pending bit changes.
- R10: As master (`is_slave`=0), if the cascade word's bit for the winning index is 1, the block does not drive a vector. From the cycle after the first strobe, `cas_out` carries the winning index.
- R11: As slave (`is_slave`=1), the block drives the vector only when `cas_in` equals the cascade word's bits 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | One-cycle I/O write strobe |
| wr_a0 | input | 1 | Register offset: 0 = base, 1 = base+1 |
| wr_data | input | 8 | Write data |
| irq_req | input | 8 | Interrupt request lines, index 0 highest priority |
| ack_strobe | input | 1 | One pulse per interrupt acknowledge cycle |
| is_slave | input | 1 | 1 selects slave behaviour in cascade |
| cas_in | input | 3 | Cascade address seen by a slave |
| init_done | output | 1 | Initialization sequence complete |
| int_out | output | 1 | Unmasked request pending |
| in_service | output | 8 | Acknowledged lines since last restart |
| cas_out | output | 3 | Index chosen at the last first strobe |
| vec_valid | output | 1 | Vector byte present on vec_data |
| vec_data | output | 8 | Vector byte |

## Verification
Every result appears one clock after the edge that samples its cause:
- `init_done` follows the third offset-1 write.
- `int_out` follows the request pulse.
- `in_service` and `cas_out` follow the first strobe.
- `vec_valid` with `vec_data` follows the second strobe, and drops one cycle later.

The bench drives each stimulus for one cycle starting at a falling edge. It samples at the next falling edge, which is half a period after the edge that registers the result. So every check lands in the cycle its result is due, and no check waits extra cycles.

// File: rtl/pic_front_pkg.sv
package pic_front_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BASE  = 3'd1,
    ST_CASC  = 3'd2,
    ST_MODE  = 3'd3,
    ST_READY = 3'd4
  } init_st_t;

  localparam int RESTART_BIT = 4;
endpackage

// File: rtl/pic_init_ctrl.sv
module pic_init_ctrl
  import pic_front_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_a0,
  input  logic [DW-1:0] wr_data,
  output logic          restart,
  output logic          ready,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_cfg,
  output logic [DW-1:0] mask
);
  init_st_t st_q;

  // Restart decode: offset 0 with the restart bit set.
  assign restart = wr_en && !wr_a0 && wr_data[RESTART_BIT];
  assign ready   = (st_q == ST_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      vec_base <= '0;
      casc_cfg <= '0;
      mask     <= '0;
    end else if (restart) begin
      st_q <= ST_BASE;
      mask <= '0;
    end else if (wr_en && wr_a0) begin
      unique case (st_q)
        ST_BASE: begin
          vec_base <= wr_data;
          st_q     <= ST_CASC;
        end
        ST_CASC: begin
          casc_cfg <= wr_data;
          st_q     <= ST_MODE;
        end
        ST_MODE:  st_q <= ST_READY;
        ST_READY: mask <= wr_data;
        default:  st_q <= st_q;
      endcase
    end
  end
endmodule

// File: rtl/pic_req_unit.sv
module pic_req_unit #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          restart,
  input  logic [N-1:0]  irq_req,
  input  logic [N-1:0]  mask,
  input  logic          take,
  output logic          any_elig,
  output logic          win_found,
  output logic [IW-1:0] win_idx,
  output logic [N-1:0]  in_service
);
  logic [N-1:0] pend_q;
  logic [N-1:0] elig;

  assign elig     = pend_q & ~mask;
  assign any_elig = ready && (|elig);

  // Fixed priority: the lowest index wins, so scan downward.
  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win_found = 1'b1;
        win_idx   = IW'(i);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    logic hit;
    assign hit = take && win_found && (win_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g]     <= 1'b0;
        in_service[g] <= 1'b0;
      end else if (restart || !ready) begin
        pend_q[g]     <= 1'b0;
        in_service[g] <= 1'b0;
      end else begin
        pend_q[g] <= irq_req[g] | (pend_q[g] & ~hit);
        if (hit) in_service[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_ack_unit.sv
module pic_ack_unit #(
  parameter int DW = 8,
  parameter int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          restart,
  input  logic          ack_strobe,
  input  logic          win_found,
  input  logic [IW-1:0] win_idx,
  input  logic [DW-1:0] vec_base,
  input  logic [DW-1:0] casc_cfg,
  input  logic          is_slave,
  input  logic [IW-1:0] cas_in,
  output logic          take,
  output logic          vec_valid,
  output logic [DW-1:0] vec_data,
  output logic [IW-1:0] cas_out
);
  logic phase_q;
  logic spur_q;
  logic second;
  logic drive;

  assign take   = ready && !restart && ack_strobe && !phase_q;
  assign second = ready && !restart && ack_strobe &&  phase_q;

  always_comb begin
    if (is_slave) drive = (cas_in == casc_cfg[IW-1:0]);
    else          drive = spur_q || !casc_cfg[cas_out];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      spur_q    <= 1'b0;
      cas_out   <= '0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= 1'b0;
      if (restart || !ready) begin
        phase_q <= 1'b0;
      end else if (take) begin
        phase_q <= 1'b1;
        spur_q  <= !win_found;
        cas_out <= win_found ? win_idx : '1;
      end else if (second) begin
        phase_q <= 1'b0;
        if (drive) begin
          vec_valid <= 1'b1;
          vec_data  <= {vec_base[DW-1:IW], cas_out};
        end
      end
    end
  end
endmodule

// File: rtl/pic_front.sv
module pic_front #(
  parameter int NUM_IRQ = 8,
  localparam int IW     = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_a0,
  input  logic [NUM_IRQ-1:0] wr_data,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               ack_strobe,
  input  logic               is_slave,
  input  logic [IW-1:0]      cas_in,
  output logic               init_done,
  output logic               int_out,
  output logic [NUM_IRQ-1:0] in_service,
  output logic [IW-1:0]      cas_out,
  output logic               vec_valid,
  output logic [NUM_IRQ-1:0] vec_data
);
  logic               restart;
  logic               ready;
  logic               take;
  logic               win_found;
  logic [IW-1:0]      win_idx;
  logic [NUM_IRQ-1:0] vec_base;
  logic [NUM_IRQ-1:0] casc_cfg;
  logic [NUM_IRQ-1:0] mask;

  assign init_done = ready;

  pic_init_ctrl #(.DW(NUM_IRQ)) u_init (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_a0(wr_a0), .wr_data(wr_data),
    .restart(restart), .ready(ready), .vec_base(vec_base),
    .casc_cfg(casc_cfg), .mask(mask)
  );

  pic_req_unit #(.N(NUM_IRQ), .IW(IW)) u_req (
    .clk(clk), .rst_n(rst_n), .ready(ready), .restart(restart),
    .irq_req(irq_req), .mask(mask), .take(take), .any_elig(int_out),
    .win_found(win_found), .win_idx(win_idx), .in_service(in_service)
  );

  pic_ack_unit #(.DW(NUM_IRQ), .IW(IW)) u_ack (
    .clk(clk), .rst_n(rst_n), .ready(ready), .restart(restart),
    .ack_strobe(ack_strobe), .win_found(win_found), .win_idx(win_idx),
    .vec_base(vec_base), .casc_cfg(casc_cfg), .is_slave(is_slave),
    .cas_in(cas_in), .take(take), .vec_valid(vec_valid),
    .vec_data(vec_data), .cas_out(cas_out)
  );
endmodule

// File: rtl/pic_front_sva.sv
module pic_front_sva #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_a0,
  input logic [N-1:0] wr_data,
  input logic         ack_strobe,
  input logic         init_done,
  input logic         int_out,
  input logic         vec_valid,
  input logic [N-1:0] in_service
);
  assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_a0 && wr_data[4]) |=> (!init_done && in_service == '0));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (!int_out && !vec_valid));

  assert_vec_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  assert_vec_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_strobe));

  assert_isr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done)) |->
      ($countones(in_service) >= $countones($past(in_service)) &&
       $countones(in_service) <= $countones($past(in_service)) + 1));
endmodule

bind pic_front pic_front_sva #(.N(NUM_IRQ)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_a0(wr_a0), .wr_data(wr_data),
  .ack_strobe(ack_strobe), .init_done(init_done), .int_out(int_out),
  .vec_valid(vec_valid), .in_service(in_service)
);

// File: tb/tb_pic_front.sv
module tb_pic_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_a0 = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] irq_req = '0;
  logic       ack_strobe = 1'b0;
  logic       is_slave = 1'b0;
  logic [2:0] cas_in = '0;
  logic       init_done, int_out, vec_valid;
  logic [7:0] in_service, vec_data;
  logic [2:0] cas_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pic_front dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_a0(wr_a0), .wr_data(wr_data),
    .irq_req(irq_req), .ack_strobe(ack_strobe), .is_slave(is_slave),
    .cas_in(cas_in), .init_done(init_done), .int_out(int_out),
    .in_service(in_service), .cas_out(cas_out), .vec_valid(vec_valid),
    .vec_data(vec_data)
  );

  // {vector base, mask, request pulse, expected vector}
  localparam logic [31:0] VEC_TAB [8] = '{
    32'h08_00_01_08, 32'h08_00_0C_0A, 32'h20_00_80_27, 32'h70_01_03_71,
    32'h70_FF_10_77, 32'hF8_00_60_FD, 32'hA8_F0_F8_AB, 32'h48_00_00_4F
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a0, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_a0 = a0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_irq(input logic [7:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic ack();
    @(negedge clk);
    ack_strobe = 1'b1;
    @(negedge clk);
    ack_strobe = 1'b0;
  endtask

  task automatic init_seq(input logic [7:0] base, input logic [7:0] casc);
    wr(1'b0, 8'h11);
    wr(1'b1, base);
    wr(1'b1, casc);
    wr(1'b1, 8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset init_done", init_done, 0);
    check("reset int_out", int_out, 0);
    check("reset vec_valid", vec_valid, 0);

    // R4: nothing happens before initialization
    pulse_irq(8'h01);
    check("R4 int_out idle", int_out, 0);
    ack();
    ack();
    check("R4 no vector idle", vec_valid, 0);

    // R2: ordered four-write sequence, restart bits do not shorten it
    wr(1'b0, 8'h13);
    check("R2 after restart", init_done, 0);
    wr(1'b1, 8'h08);
    check("R2 after base", init_done, 0);
    wr(1'b1, 8'h00);
    check("R2 after cascade", init_done, 0);
    wr(1'b1, 8'h01);
    check("R2 after mode", init_done, 1);

    // Table walk: R7/R8/R9/R5 across patterns
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e;
      e = VEC_TAB[i];
      init_seq(e[31:24], 8'h00);
      wr(1'b1, e[23:16]);
      pulse_irq(e[15:8]);
      ack();
      ack();
      check($sformatf("R8 table %0d valid", i), vec_valid, 1);
      check($sformatf("R8 table %0d data", i), vec_data, e[7:0]);
      @(negedge clk);
      check($sformatf("R8 table %0d pulse", i), vec_valid, 0);
    end

    // R6/R7: pending, then acknowledge clears it and sets in-service
    init_seq(8'h0D, 8'h00);
    pulse_irq(8'h08);
    check("R6 int_out", int_out, 1);
    ack();
    check("R7 in_service", in_service, 8'h08);
    check("R7 pending cleared", int_out, 0);
    ack();
    check("R8 low bits of base ignored", vec_data, 8'h0B);

    // R3: offset-0 write without restart bit changes nothing
    wr(1'b0, 8'h0F);
    check("R3 init kept", init_done, 1);
    check("R3 in_service kept", in_service, 8'h08);

    // R5: mask hides a pending line, unmask reveals it
    wr(1'b1, 8'h04);
    pulse_irq(8'h04);
    check("R5 masked", int_out, 0);
    wr(1'b1, 8'h00);
    check("R5 unmasked", int_out, 1);
    ack();
    check("R5 winner after unmask", in_service, 8'h0C);
    ack();

    // R9: spurious acknowledge keeps in-service unchanged
    ack();
    check("R9 in_service unchanged", in_service, 8'h0C);
    check("R9 cas index", cas_out, 3'd7);
    ack();
    check("R9 spurious vector", vec_data, 8'h0F);

    // R1: restart clears mask and in-service
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h10);
    check("R1 init dropped", init_done, 0);
    check("R1 in_service cleared", in_service, 8'h00);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h01);
    pulse_irq(8'h80);
    check("R1 mask cleared", int_out, 1);

    // R10: master stays silent on a cascaded line
    init_seq(8'h40, 8'h10);
    pulse_irq(8'h10);
    ack();
    check("R10 cas_out", cas_out, 3'd4);
    ack();
    check("R10 silent", vec_valid, 0);
    pulse_irq(8'h02);
    ack();
    ack();
    check("R10 non-cascaded valid", vec_valid, 1);
    check("R10 non-cascaded data", vec_data, 8'h41);

    // R11: slave drives only on matching cascade address
    is_slave = 1'b1;
    cas_in = 3'd2;
    init_seq(8'h70, 8'h02);
    pulse_irq(8'h01);
    ack();
    ack();
    check("R11 match valid", vec_valid, 1);
    check("R11 match data", vec_data, 8'h70);
    cas_in = 3'd5;
    pulse_irq(8'h01);
    ack();
    ack();
    check("R11 mismatch silent", vec_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule